// File: doc/BRIEF.md
# Stack Processor Instruction Sequencer

This block fetches and sequences instructions for a compact zero-operand processor built around two stacks. It reads 9-bit words from a program memory with a one-cycle synchronous read. Nine bits is the natural width of a block RAM, so the ninth bit is put to use instead of carrying parity. The sequencer owns the program counter and the return stack. It executes jumps, calls, returns and literals itself. Every other opcode goes to an external data-stack datapath as a one-cycle strobe.

On plain opcodes the ninth bit asks for a return folded into the same instruction. The return costs no fetch of its own. Branch words use the ninth bit as the sign bit of their offset. Literal words use it as the top bit of the value. A return instruction ignores it.

Top module: `stk_seq`

## Requirements
- R1: While reset is held, `imem_addr` is 0, `valid_op` and `lit_valid` are 0 and `rstk_err` is 0. The first word executed after reset is the word at address 0.
- R2: Plain words have bit 7 = 0 and bits 6:5 equal to 00 or 11. Those with bits 7:0 in 0x00–0x1F or 0x61–0x63 are defined opcodes. A defined opcode pulses `valid_op` for one cycle with `opcode` = bits 7:0, and instructions that do not transfer control execute one per cycle.
- R3: A word with bit 7 = 1 is a literal. It pulses `lit_valid` with `lit` = {bit 8, bits 6:0}, and it never returns, whatever bit 8 holds.
- R4: Bits 7:5 = 001 is a jump. The new PC is the jump's own address plus the signed 5-bit offset {bit 8, bits 3:0}. A jump drives no strobe.
- R5: Bits 7:5 = 010 is a call. It branches to the same kind of target as a jump and pushes its own address + 1 onto the return stack, which holds 16 entries.
- R6: A plain word with bit 8 = 1 executes and then continues at the popped return address. No separate return word is fetched.
- R7: Word bits 7:0 = 0x60 is a return. It pops exactly one entry, whether bit 8 is set or not, and drives no strobe.
- R8: Plain codes 0x64–0x7F are no-ops that drive no strobe, but they still honour the bit 8 return.
- R9: Every taken jump, call or return, folded or not, is followed by exactly one cycle in which nothing executes.
- R10: A call made with 16 entries already on the stack sets `rstk_err`. The call is still taken.
- R11: A pop from an empty stack sets `rstk_err` and sends the PC to address 0.
- R12: `rstk_err` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | AW (10) | Program memory read address |
| imem_rdata | input | 9 | Program word, one cycle after its address |
| valid_op | output | 1 | Plain opcode strobe |
| opcode | output | 8 | Opcode, valid with `valid_op` |
| lit_valid | output | 1 | Literal strobe |
| lit | output | 8 | Literal value, valid with `lit_valid` |
| rstk_err | output | 1 | Sticky return-stack overflow/underflow flag |

## Verification
The bench checks every strobe against an expected cycle as well as an expected value, so a missing or doubled bubble shows up as a timing mismatch.

- **Literal with bit 8 set.** One program places such a literal early on. If it were treated as a fold, the run would underflow and jump back to 0.
- **Return with bit 8 set.** A return word carries bit 8 = 1. A design that popped twice would corrupt the later trace and raise the error flag.
- **Branch offsets.** Negative and positive offsets both appear, which catches a design that drops the sign bit.
- **Stack limits.** A self-call loop overflows the stack, with the flag checked just before and just after the seventeenth push. An underflowing return is checked for its jump to address 0.

// File: rtl/stk_seq_pkg.sv
package stk_seq_pkg;
   typedef enum logic [2:0] {
      K_NONE, K_PLAIN, K_LIT, K_JMP, K_CALL, K_RET, K_ILL
   } kind_t;

   localparam int WORD_W   = 9;
   localparam int OFF_W    = 5;
   localparam logic [7:0] RET_CODE = 8'h60;
endpackage

// File: rtl/stk_seq_dec.sv
module stk_seq_dec
   import stk_seq_pkg::*;
#(
   parameter int AW     = 10,
   parameter int OPS_HI = 4
) (
   input  logic              en,
   input  logic [WORD_W-1:0] word,
   input  logic [AW-1:0]     epc,
   output kind_t             kind,
   output logic              push,
   output logic              pop,
   output logic              branch,
   output logic [AW-1:0]     target,
   output logic              op_stb,
   output logic              lit_stb,
   output logic [7:0]        lit_val
);
   initial begin
      if (AW < OFF_W) $error("AW must be at least the offset width");
      if (OPS_HI < 1 || OPS_HI > 32) $error("OPS_HI out of range");
   end

   logic [AW-1:0] off_ext;
   assign off_ext = {{(AW-OFF_W){word[8]}}, word[8], word[3:0]};
   assign target  = epc + off_ext;

   always_comb begin
      kind = K_NONE;
      if (en) begin
         if (word[7])
            kind = K_LIT;
         else if (word[6:5] == 2'b01)
            kind = K_JMP;
         else if (word[6:5] == 2'b10)
            kind = K_CALL;
         else if (word[7:0] == RET_CODE)
            kind = K_RET;
         else if (word[6:5] == 2'b00 || int'(word[4:0]) < OPS_HI)
            kind = K_PLAIN;
         else
            kind = K_ILL;
      end
   end

   assign push    = (kind == K_CALL);
   assign branch  = (kind == K_JMP) || (kind == K_CALL);
   assign pop     = (kind == K_RET) ||
                    (((kind == K_PLAIN) || (kind == K_ILL)) && word[8]);
   assign op_stb  = (kind == K_PLAIN);
   assign lit_stb = (kind == K_LIT);
   assign lit_val = {word[8], word[6:0]};
endmodule

// File: rtl/stk_seq_rstack.sv
module stk_seq_rstack #(
   parameter int AW    = 10,
   parameter int DEPTH = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic [AW-1:0] push_data,
   output logic [AW-1:0] top_data,
   output logic          err
);
   localparam int SPW = $clog2(DEPTH + 1);
   localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   initial begin
      if (DEPTH < 2) $error("DEPTH must be at least 2");
   end

   logic [SPW-1:0] sp;
   logic [AW-1:0]  ent [DEPTH];
   logic           full, empty;

   assign full  = (sp == SPW'(DEPTH));
   assign empty = (sp == '0);

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ent[i] <= '0;
         else if (push && sp == SPW'(i))
            ent[i] <= push_data;
      end
   end

   assign top_data = empty ? '0 : ent[IW'(sp - 1'b1)];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp  <= '0;
         err <= 1'b0;
      end else begin
         if (push) begin
            if (full) err <= 1'b1;
            else      sp  <= sp + 1'b1;
         end else if (pop) begin
            if (empty) err <= 1'b1;
            else       sp  <= sp - 1'b1;
         end
      end
   end

   // R10
   sp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sp <= SPW'(DEPTH));
   // R11
   underflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && empty) |=> err);
   // R12
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);
endmodule

// File: rtl/stk_seq.sv
module stk_seq
   import stk_seq_pkg::*;
#(
   parameter int AW       = 10,
   parameter int RS_DEPTH = 16,
   parameter int OPS_HI   = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [AW-1:0] imem_addr,
   input  logic [8:0]    imem_rdata,
   output logic          valid_op,
   output logic [7:0]    opcode,
   output logic          lit_valid,
   output logic [7:0]    lit,
   output logic          rstk_err
);
   logic [AW-1:0] pc, epc, rel_tgt, ret_tgt;
   logic          fv;
   kind_t         kind;
   logic          push, pop, branch, op_stb, lit_stb, taken;
   logic [7:0]    lit_val;

   stk_seq_dec #(.AW(AW), .OPS_HI(OPS_HI)) u_dec (
      .en(fv), .word(imem_rdata), .epc(epc), .kind(kind),
      .push(push), .pop(pop), .branch(branch), .target(rel_tgt),
      .op_stb(op_stb), .lit_stb(lit_stb), .lit_val(lit_val)
   );

   stk_seq_rstack #(.AW(AW), .DEPTH(RS_DEPTH)) u_rs (
      .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
      .push_data(epc + 1'b1), .top_data(ret_tgt), .err(rstk_err)
   );

   assign taken = branch || pop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc  <= '0;
         epc <= '0;
         fv  <= 1'b0;
      end else if (taken) begin
         pc  <= pop ? ret_tgt : rel_tgt;
         fv  <= 1'b0;
      end else begin
         pc  <= pc + 1'b1;
         epc <= pc;
         fv  <= 1'b1;
      end
   end

   assign imem_addr = pc;
   assign valid_op  = op_stb;
   assign opcode    = op_stb ? imem_rdata[7:0] : 8'h00;
   assign lit_valid = lit_stb;
   assign lit       = lit_stb ? lit_val : 8'h00;

   // R2
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid_op && lit_valid));
   // R9
   bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      taken |=> (!valid_op && !lit_valid && !fv));
   // R3
   lit_noret_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lit_valid |=> fv);
   // R6
   fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_op && imem_rdata[8]) |=> !fv);
endmodule

// File: tb/sim_stk_seq.sv
module sim_stk_seq;
   localparam int AW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] imem_addr;
   logic [8:0]    imem_rdata = '0;
   logic          valid_op, lit_valid, rstk_err;
   logic [7:0]    opcode, lit;

   logic [8:0] mem [0:(1<<AW)-1];

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit running = 0;

   int    qk[$];
   int    qv[$];
   int    qc[$];
   string qr[$];

   always #10 clk = ~clk;

   always @(posedge clk) imem_rdata <= mem[imem_addr];

   stk_seq u0 (
      .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
      .valid_op(valid_op), .opcode(opcode), .lit_valid(lit_valid), .lit(lit),
      .rstk_err(rstk_err)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // kind 0 = opcode strobe, 1 = literal strobe
   task automatic expect_item(input int k, input int v, input int c, input string tag);
      qk.push_back(k); qv.push_back(v); qc.push_back(c); qr.push_back(tag);
   endtask

   // monitor: pops expected items as strobes appear
   always @(negedge clk) begin
      if (running) begin
         cyc++;
         if (valid_op || lit_valid) begin
            if (qk.size() == 0) begin
               chk(0, "unexpected strobe R2/R3", cyc, 0);
            end else begin
               int k, v, c;
               string t;
               k = qk.pop_front(); v = qv.pop_front();
               c = qc.pop_front(); t = qr.pop_front();
               chk(lit_valid == (k == 1), {t, " kind"}, int'(lit_valid), k);
               chk(((k == 1) ? int'(lit) : int'(opcode)) == v, {t, " value"},
                   (k == 1) ? int'(lit) : int'(opcode), v);
               chk(cyc == c, {t, " cycle"}, cyc, c);
            end
         end
      end
   end

   task automatic start_prog();
      rst_n = 1'b0;
      running = 0;
      repeat (2) @(negedge clk);
      // R1 reset state
      chk(imem_addr == '0, "R1 addr", int'(imem_addr), 0);
      chk(!valid_op && !lit_valid, "R1 strobes", int'(valid_op || lit_valid), 0);
      chk(!rstk_err, "R1 err", int'(rstk_err), 0);
      rst_n = 1'b1;
      @(posedge clk);
      cyc = 0;
      running = 1;
   endtask

   task automatic finish_prog();
      chk(qk.size() == 0, "missing strobes", qk.size(), 0);
      qk.delete(); qv.delete(); qc.delete(); qr.delete();
      running = 0;
   endtask

   task automatic clear_mem();
      for (int i = 0; i < (1 << AW); i++) mem[i] = 9'h020;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // Program 1: sequencing, literals, call, fold, jump, illegal
      clear_mem();
      mem[0]  = 9'h005;  // op 05
      mem[1]  = 9'h1A3;  // literal A3 (bit 8 set)
      mem[2]  = 9'h095;  // literal 15
      mem[3]  = 9'h043;  // call +3 -> 6, push 4
      mem[4]  = 9'h061;  // op 61
      mem[5]  = 9'h025;  // jump +5 -> 10
      mem[6]  = 9'h11F;  // op 1F with fold -> 4
      mem[10] = 9'h070;  // illegal no-op
      mem[11] = 9'h0FF;  // literal 7F
      mem[12] = 9'h020;  // jump to self
      expect_item(0, 'h05, 1,  "R1 R2 first op");
      expect_item(1, 'hA3, 2,  "R3 literal bit8");
      expect_item(1, 'h15, 3,  "R3 literal");
      expect_item(0, 'h1F, 6,  "R5 R9 call target");
      expect_item(0, 'h61, 8,  "R6 fold return");
      expect_item(1, 'h7F, 12, "R4 R8 jump and illegal");
      start_prog();
      wait (cyc == 16);
      #1;
      chk(!rstk_err, "R3 no spurious pop", int'(rstk_err), 0);
      finish_prog();

      // Program 2: illegal fold, RET with bit 8, offsets, underflow
      clear_mem();
      mem[0]  = 9'h044;  // call +4 -> 4, push 1
      mem[1]  = 9'h002;  // op 02
      mem[2]  = 9'h02C;  // jump +12 -> 14
      mem[4]  = 9'h044;  // call +4 -> 8, push 5
      mem[5]  = 9'h160;  // return, bit 8 set -> 1
      mem[8]  = 9'h17A;  // illegal with fold -> 5
      mem[12] = 9'h062;  // op 62
      mem[13] = 9'h060;  // return on empty stack
      mem[14] = 9'h010;  // op 10
      mem[15] = 9'h12D;  // jump -3 -> 12
      expect_item(0, 'h02, 9,  "R7 R8 single pop");
      expect_item(0, 'h10, 12, "R4 positive offset");
      expect_item(0, 'h62, 15, "R4 negative offset");
      start_prog();
      wait (cyc == 15);
      #1;
      chk(!rstk_err, "R7 no double pop", int'(rstk_err), 0);
      wait (cyc == 17);
      #1;
      chk(rstk_err, "R11 underflow flag", int'(rstk_err), 1);
      chk(imem_addr == '0, "R11 underflow target", int'(imem_addr), 0);
      finish_prog();

      // Program 3: overflow by self-call
      clear_mem();
      mem[0] = 9'h040;   // call +0 -> 0
      start_prog();
      wait (cyc == 32);
      #1;
      chk(!rstk_err, "R10 sixteen pushes fit", int'(rstk_err), 0);
      wait (cyc == 34);
      #1;
      chk(rstk_err, "R10 overflow flag", int'(rstk_err), 1);
      chk(imem_addr == '0, "R10 call still taken", int'(imem_addr), 0);
      wait (cyc == 60);
      #1;
      chk(rstk_err, "R12 flag sticky", int'(rstk_err), 1);
      finish_prog();

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule